// File: doc/BRIEF.md
# Interrupt Status, Sticky and Mask Controller

This block gathers the fault and calibration conditions of a clock synthesis core and presents them to software through three byte-wide registers. The first shows the live conditions, the second latches every condition that has been seen until software clears it, and the third masks conditions out of a single active-high interrupt line. The interrupt line is not latched. It is high only while at least one unmasked live condition is high. A host should therefore treat it as an edge source and read the sticky register to learn which event fired.

Five condition inputs enter asynchronously and pass through a two-flop synchronizer before any register logic sees them. The input at position 1 is reserved and has no effect. While power-on reset (`rst_n` low) or a soft reset (`soft_rst_i` high) is active, the calibration condition is forced high and the loss-of-lock condition is forced low. This keeps the interrupt from chattering while lock is acquired. With a suitable mask, the interrupt line becomes a pin indicator for any single fault or for any chosen set of faults.

Top module: `irq_status_ctrl`

## Requirements
- R1: A read at address 218 returns the live status. Bit 0 is calibration in progress, bit 2 is clock-input loss of signal, bit 3 is feedback loss of signal and bit 4 is loss of lock. A change on `cond_i` appears there two rising clock edges later.
- R2: A read at address 247 returns the sticky register, which uses the same bit layout. A sticky bit sets on the rising edge after its live bit is seen high, and it stays set while no clearing write occurs.
- R3: A write to address 247 clears every sticky bit whose write-data bit is 0. Sticky bits whose write-data bit is 1 keep their value.
- R4: If a live bit is high on the same edge as a write that would clear its sticky bit, the sticky bit stays set.
- R5: The mask register is at address 6. A write there stores bits [4:0], the register reads back those bits, and bits [7:5] read as zero.
- R6: `intr_o` equals the OR of the live status bits whose mask bit is 0. It follows the live status in the same cycle and holds no memory of earlier values.
- R7: While `rst_n` is low or `soft_rst_i` is high, live status bit 0 reads 1 and live status bit 4 reads 0, whatever the inputs are.
- R8: Bit 1 and bits [7:5] of the status and sticky registers always read 0. `cond_i[1]` affects neither register nor `intr_o`, and writes cannot set those bits.
- R9: After reset, the mask and sticky registers both read 0, which leaves every source enabled.
- R10: A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| soft_rst_i | input | 1 | Soft reset: forces calibration high and loss of lock low |
| cond_i | input | 5 | Asynchronous conditions: [0] calibration, [1] reserved, [2] clock-input loss of signal, [3] feedback loss of signal, [4] loss of lock |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| intr_o | output | 1 | Active-high interrupt from the unmasked live status |

## Verification
The hardest case to reach is a clearing write to the sticky register that lands on exactly the edge where the same condition is still live. Two more cases are nearly as hard: a condition that rises and falls within the two-flop synchronizer window, and a soft reset that overlaps with live faults. Random stimulus toggles the conditions every cycle and hits the three addresses with frequent writes and occasional soft resets, so these overlaps come up many times. Directed sequences then hold a condition high across a zero write and drive the reserved input alone. A cycle-accurate model of the synchronizer and registers in the bench predicts every read and every interrupt value.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt status controller.
// Assumes byte-wide registers and five condition inputs, one of them reserved.
package irq_pkg;
    localparam int REG_W     = 8;
    localparam int N_COND    = 5;
    localparam int CAL_BIT   = 0;
    localparam int RSV_BIT   = 1;
    localparam int LOSIN_BIT = 2;
    localparam int LOSFB_BIT = 3;
    localparam int LOL_BIT   = 4;
    // Status bits that carry a real condition
    localparam logic [REG_W-1:0] STAT_VALID = (REG_W'(1) << CAL_BIT) | (REG_W'(1) << LOSIN_BIT)
                                            | (REG_W'(1) << LOSFB_BIT) | (REG_W'(1) << LOL_BIT);
    // Writable mask bits
    localparam logic [REG_W-1:0] MASK_VALID = REG_W'((1 << N_COND) - 1);
endpackage

// File: rtl/irq_cond_sync.sv
// Module: two-flop synchronizer, one chain per condition input.
// Assumes inputs are asynchronous level signals. Chains reset to 0.
module irq_cond_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_i[b]};
        end

        assign sync_o[b] = chain[LAST];
    end
endmodule

// File: rtl/irq_status_view.sv
// Module: forms the live status byte from the synchronized conditions.
// Assumes the bit layout from irq_pkg. During a hard or soft reset it forces
// calibration high and loss of lock low, and it zeroes reserved positions.
module irq_status_view
    import irq_pkg::*;
(
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic [N_COND-1:0] sync_i,
    output logic [REG_W-1:0]  live_o
);
    logic hold;

    assign hold = !rst_n || soft_rst_i;

    // Apply the reserved-bit mask and the reset overrides
    always_comb begin
        live_o = {{(REG_W-N_COND){1'b0}}, sync_i} & STAT_VALID;
        if (hold) begin
            live_o[CAL_BIT] = 1'b1;
            live_o[LOL_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_sticky_bank.sv
// Module: sticky copy of the live status with write-zero-to-clear.
// Assumes keep_i is sampled only when clr_wr_i is high. Setting takes priority
// over clearing, and reserved positions stay 0.
module irq_sticky_bank #(
    parameter int               W     = 8,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] keep_i,
    output logic [W-1:0] sticky_o
);
    logic [W-1:0] kept;

    // Bits that survive a clearing write
    assign kept = clr_wr_i ? (sticky_o & keep_i) : sticky_o;

    // Latch any live condition, with set winning over clear
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_o <= '0;
        else        sticky_o <= (kept | live_i) & VALID;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the interrupt status controller. It holds the live view,
// the sticky view, the mask register and the read mux, and it drives the
// unlatched interrupt. Assumes one write per cycle, with combinational read data.
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 218,
    parameter int STICKY_ADDR = 247,
    parameter int MASK_ADDR   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic [N_COND-1:0] cond_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              wr_en_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              intr_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_STK  = ADDR_W'(STICKY_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    logic [N_COND-1:0] cond_sync;
    logic [REG_W-1:0]  live_stat;
    logic [REG_W-1:0]  sticky_q;
    logic [REG_W-1:0]  mask_q;
    logic              sticky_wr;
    logic              mask_wr;

    irq_cond_sync #(.W(N_COND), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cond_i),
        .sync_o  (cond_sync)
    );

    irq_status_view u_view (
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .sync_i     (cond_sync),
        .live_o     (live_stat)
    );

    assign sticky_wr = wr_en_i && (addr_i == A_STK);
    assign mask_wr   = wr_en_i && (addr_i == A_MASK);

    irq_sticky_bank #(.W(REG_W), .VALID(STAT_VALID)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_i   (live_stat),
        .clr_wr_i (sticky_wr),
        .keep_i   (wdata_i),
        .sticky_o (sticky_q)
    );

    // Mask register: store writable bits only
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata_i & MASK_VALID;
    end

    // Read mux over the three register views
    always_comb begin
        unique case (addr_i)
            A_STAT:  rdata_o = live_stat;
            A_STK:   rdata_o = sticky_q;
            A_MASK:  rdata_o = mask_q;
            default: rdata_o = '0;
        endcase
    end

    // Interrupt: any live condition not masked, no latching
    assign intr_o = |(live_stat & ~mask_q);
endmodule

// File: rtl/irq_status_chk.sv
// Module: assertion checker for irq_status_ctrl, attached by bind.
// Assumes the internal signal names of the top module.
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STICKY_ADDR = 247,
    parameter int MASK_ADDR   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  wdata_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  live_stat,
    input logic [REG_W-1:0]  sticky_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              intr_o
);
    AST_STICKY_ONLY_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ((($past(sticky_q) & ~sticky_q)) != '0) |->
        $past(wr_en_i) && ($past(addr_i) == ADDR_W'(STICKY_ADDR))); // R3
    AST_SET_WINS_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((sticky_q & $past(live_stat)) == $past(live_stat))); // R4
    AST_SOFT_RESET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |-> (live_stat[CAL_BIT] && !live_stat[LOL_BIT])); // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_stat | sticky_q) & ~STAT_VALID) == '0); // R8
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_W'(MASK_ADDR)) |=> $stable(mask_q)); // R5
    AST_INTR_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> ((live_stat & ~mask_q) != '0)); // R6
endmodule

bind irq_status_ctrl irq_status_chk #(
    .ADDR_W(ADDR_W), .STICKY_ADDR(STICKY_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_en_i(wr_en_i), .live_stat(live_stat),
    .sticky_q(sticky_q), .mask_q(mask_q), .intr_o(intr_o)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    localparam logic [7:0] A_STAT = 8'd218;
    localparam logic [7:0] A_STK  = 8'd247;
    localparam logic [7:0] A_MASK = 8'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_i = 1'b0;
    logic [4:0] cond_i = '0;
    logic [7:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] rdata_o;
    logic       intr_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [4:0] m_s1 = '0, m_s2 = '0;
    logic [7:0] m_stk = '0, m_msk = '0;

    always #4 clk = ~clk;   // 125 MHz

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .cond_i(cond_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .wr_en_i(wr_en_i),
        .rdata_o(rdata_o), .intr_o(intr_o)
    );

    function automatic logic [7:0] live_of(logic [4:0] s, logic rn, logic sr);
        logic [7:0] v;
        v = {3'b000, s} & 8'h1D;
        if (!rn || sr) begin
            v[0] = 1'b1;
            v[4] = 1'b0;
        end
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (a == A_STAT) return live_of(m_s2, rst_n, soft_rst_i);
        if (a == A_STK)  return m_stk;
        if (a == A_MASK) return m_msk;
        return 8'h00;
    endfunction

    function automatic logic exp_intr();
        return |(live_of(m_s2, rst_n, soft_rst_i) & ~m_msk);
    endfunction

    // Reference update on each edge from the inputs held since the last negedge
    always @(posedge clk) begin
        logic [7:0] lv;
        lv = live_of(m_s2, rst_n, soft_rst_i);
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_stk <= '0; m_msk <= '0;
        end else begin
            m_stk <= (((wr_en_i && addr_i == A_STK) ? (m_stk & wdata_i) : m_stk) | lv) & 8'h1D;
            if (wr_en_i && addr_i == A_MASK) m_msk <= wdata_i & 8'h1F;
            m_s2 <= m_s1;
            m_s1 <= cond_i;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string req_of(logic [7:0] a);
        if (a == A_STAT) return "R1";
        if (a == A_STK)  return "R2/R3";
        if (a == A_MASK) return "R5";
        return "R10";
    endfunction

    // Compare both outputs against the model at the current negedge
    task automatic check_now();
        chk(req_of(addr_i), rdata_o, exp_rd(addr_i));
        chk("R6", {7'b0, intr_o}, {7'b0, exp_intr()});
    endtask

    task automatic step(logic [4:0] c, logic [7:0] a, logic w, logic [7:0] d, logic s);
        cond_i = c; addr_i = a; wr_en_i = w; wdata_i = d; soft_rst_i = s;
        @(negedge clk);
        check_now();
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset state, with calibration forced during reset (R7, R9)
        cond_i = 5'h1F;
        repeat (3) @(negedge clk);
        addr_i = A_STAT; #1; chk("R7", rdata_o, 8'h01);
        chk("R7", {7'b0, intr_o}, 8'h01);
        addr_i = A_STK;  #1; chk("R9", rdata_o, 8'h00);
        addr_i = A_MASK; #1; chk("R9", rdata_o, 8'h00);
        cond_i = '0;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) step(5'h00, A_STK, 1'b1, 8'h00, 1'b0);
        chk("R9", rdata_o, 8'h00);

        // Reserved input alone changes nothing (R8)
        repeat (4) step(5'h02, A_STAT, 1'b0, 8'h00, 1'b0);
        chk("R8", rdata_o, 8'h00);
        chk("R8", {7'b0, intr_o}, 8'h00);
        step(5'h02, A_STK, 1'b1, 8'hFF, 1'b0);
        step(5'h02, A_STK, 1'b0, 8'h00, 1'b0);
        chk("R8", rdata_o, 8'h00);

        // Two-edge latency on the live view (R1)
        step(5'h04, A_STAT, 1'b0, 8'h00, 1'b0);
        chk("R1", rdata_o, 8'h00);
        step(5'h04, A_STAT, 1'b0, 8'h00, 1'b0);
        chk("R1", rdata_o, 8'h04);

        // Clear while still live: bit stays set (R4)
        step(5'h04, A_STK, 1'b1, 8'h00, 1'b0);
        step(5'h00, A_STK, 1'b0, 8'h00, 1'b0);
        chk("R4", rdata_o, 8'h04);
        repeat (3) step(5'h00, A_STK, 1'b0, 8'h00, 1'b0);
        step(5'h00, A_STK, 1'b1, 8'hFB, 1'b0);
        step(5'h00, A_STK, 1'b0, 8'h00, 1'b0);
        chk("R3", rdata_o, 8'h00);

        // Mask upper bits read as zero (R5), soft reset forcing (R7)
        step(5'h00, A_MASK, 1'b1, 8'hFF, 1'b0);
        step(5'h00, A_MASK, 1'b0, 8'h00, 1'b0);
        chk("R5", rdata_o, 8'h1F);
        step(5'h10, A_MASK, 1'b1, 8'h00, 1'b0);
        repeat (2) step(5'h10, A_STAT, 1'b0, 8'h00, 1'b1);
        chk("R7", rdata_o, 8'h01);
        step(5'h10, A_STAT, 1'b0, 8'h00, 1'b0);
        chk("R1", rdata_o, 8'h10);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            a = (sel < 3) ? A_STAT : (sel < 6) ? A_STK : (sel < 9) ? A_MASK : 8'($urandom);
            step(5'($urandom), a, ($urandom_range(0, 2) == 0), 8'($urandom),
                 ($urandom_range(0, 19) == 0));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule